// File: doc/BRIEF.md
# Memory Management Register Bank

This block is the register file behind a segmented memory management unit for a 16-bit machine with three privilege modes. It stores one descriptor and one base register for each of 8 segments, in an instruction space and a data space, for each of the kernel, supervisor and user modes. That is 48 pairs in all. It also stores the control and status words that enable translation, record faults and select split instruction/data spaces per mode. Software reaches every register through a word-wide bus that uses 18-bit byte addresses, written here in octal. The address map has gaps: kernel and supervisor banks sit in one window and user banks in another.

The address translator reads the bank through a lookup port. It presents a mode, a space and a segment number and gets back that segment's descriptor and base register in the same cycle. In the same cycle it may pulse flags that mark the segment as written or trapped. When the translator reports a fault, the block captures the fault kind, the mode, the space, the segment and the virtual address. These captured fields are then held until software clears the fault kind bits.

Top module: `mmu_reg_bank`

## Requirements
- R1: After reset every descriptor, base, status word 0, status word 2 and the split-enable word read zero, and translation is disabled.
- R2: Descriptor and base registers decode from the byte address, with bit 5 selecting base over descriptor, bit 4 selecting data space and bits 3:1 giving the segment. The window 772200–772277 is supervisor, 772300–772377 is kernel and 777600–777677 is user. Each register reads back what was last written to it, and no other register changes.
- R3: A descriptor stores only the software fields: length in bits 14:8, direction in bit 3 and access code in bits 2:0. Bits 15, 5 and 4 always read zero. Software can never set bit 7 (trapped) or bit 6 (written).
- R4: A base register keeps the low (physical address bits − 6) bits, which is 16 bits at the default of 22 and 12 bits at 18. Higher bits read zero.
- R5: A written pulse sets bit 6 and a trapped pulse sets bit 7 in the descriptor selected on the lookup port. A software write to a descriptor clears both flags, and it takes priority over a pulse to the same descriptor in the same cycle.
- R6: The lookup port uses mode code 00 for kernel, 01 for supervisor and 11 for user. It returns the selected descriptor and base in the same cycle. If the split bit for that mode is clear, a data-space request returns the instruction-space entry. Code 10 returns zeros.
- R7: A fault captures into status word 0 at 777572: kind in bits 15:13, mode in 6:5, space in 4 and segment in 3:1, with bit 0 (translation enable) unchanged. It also captures the virtual address into status word 2 at 777576.
- R8: While any of status word 0 bits 15:13 is set, later faults change neither status word 0 nor status word 2. After software clears those bits, the next fault captures again.
- R9: Status word 1 at 777574 reads zero and ignores writes. Status word 2 ignores software writes.
- R10: An odd address, or any address outside the mapped registers, raises the bus error output and reads zero. A write to such an address changes no register.
- R11: In status word 0, bits 12:7 read zero, and software writes bits 15:13, 6:1 and 0, where bit 0 drives the translation enable output. The split-enable word at 777516 keeps bit 2 (kernel), bit 1 (supervisor) and bit 0 (user), and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 18 | Byte address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, same cycle |
| busErr | output | 1 | Unmapped or odd address |
| lkMode | input | 2 | Lookup mode code |
| lkSpace | input | 1 | Lookup space, 1 = data |
| lkSeg | input | 3 | Lookup segment |
| lkDesc | output | 16 | Selected descriptor |
| lkBase | output | 16 | Selected base, zero-extended |
| xlateEnable | output | 1 | Translation enable bit |
| hwSetWritten | input | 1 | Set written flag of looked-up segment |
| hwSetTrapped | input | 1 | Set trapped flag of looked-up segment |
| faultValid | input | 1 | Fault report strobe |
| faultKind | input | 3 | Fault kind bits |
| faultMode | input | 2 | Mode of faulting access |
| faultSpace | input | 1 | Space of faulting access |
| faultSeg | input | 3 | Segment of faulting access |
| faultVa | input | 16 | Virtual address to record |

## Verification
The hardest states to reach are those where hardware and software act on the same storage in the same cycle. One case is a flag pulse aimed at a descriptor that software is rewriting at that moment. The other is a second fault arriving while an earlier capture is still held. The stimulus reaches the first case by driving a descriptor write and a written pulse to the same segment together. It reaches the second by issuing a fault, then a second fault with a different kind, address and segment before clearing status word 0, and then a third fault after the clear. A narrow second instance built for an 18-bit physical space shares the bus so that the base width masking can be seen.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;
  localparam int WORD_W        = 16;
  localparam int ADDR_W        = 18;
  localparam int SEG_UNIT_BITS = 6;
  localparam int NUM_BANKS     = 3;
  localparam int NUM_SPACES    = 2;
  localparam int NUM_SEGS      = 8;
  localparam int ENTRIES       = NUM_BANKS * NUM_SPACES * NUM_SEGS;
  localparam int IDX_W         = $clog2(ENTRIES);

  localparam logic [ADDR_W-1:0] LOW_WIN_MASK  = 18'o777600;
  localparam logic [ADDR_W-1:0] LOW_WIN_BASE  = 18'o772200;
  localparam logic [ADDR_W-1:0] USR_WIN_MASK  = 18'o777700;
  localparam logic [ADDR_W-1:0] USR_WIN_BASE  = 18'o777600;
  localparam logic [ADDR_W-1:0] ADDR_STAT0    = 18'o777572;
  localparam logic [ADDR_W-1:0] ADDR_STAT1    = 18'o777574;
  localparam logic [ADDR_W-1:0] ADDR_STAT2    = 18'o777576;
  localparam logic [ADDR_W-1:0] ADDR_SPLIT    = 18'o777516;

  localparam logic [WORD_W-1:0] DESC_SW_MASK  = 16'h7F0F;
  localparam logic [WORD_W-1:0] STAT0_MASK    = 16'hE07F;
  localparam int FLAG_WRITTEN = 6;
  localparam int FLAG_TRAPPED = 7;

  localparam logic [1:0] BANK_KERN = 2'd0;
  localparam logic [1:0] BANK_SUPV = 2'd1;
  localparam logic [1:0] BANK_USER = 2'd2;

  typedef enum logic [2:0] {
    REG_NONE, REG_DESC, REG_BASE, REG_STAT0, REG_STAT1, REG_STAT2, REG_SPLIT
  } regKind_t;

  typedef struct packed {
    logic       rdEn;
    logic       wrEn;
    logic       err;
    regKind_t   kind;
    logic [1:0] bank;
    logic       space;
    logic [2:0] seg;
  } busStrobe_t;
endpackage

// File: rtl/mmu_bank_decode.sv
module mmu_bank_decode
  import mmu_bank_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        stb
);
  always_comb begin
    stb      = '0;
    stb.kind = REG_NONE;
    if (busSel) begin
      if (busAddr[0]) begin
        stb.err = 1'b1;
      end else if ((busAddr & LOW_WIN_MASK) == LOW_WIN_BASE) begin
        stb.kind  = busAddr[5] ? REG_BASE : REG_DESC;
        stb.bank  = busAddr[6] ? BANK_KERN : BANK_SUPV;
        stb.space = busAddr[4];
        stb.seg   = busAddr[3:1];
      end else if ((busAddr & USR_WIN_MASK) == USR_WIN_BASE) begin
        stb.kind  = busAddr[5] ? REG_BASE : REG_DESC;
        stb.bank  = BANK_USER;
        stb.space = busAddr[4];
        stb.seg   = busAddr[3:1];
      end else begin
        case (busAddr)
          ADDR_STAT0: stb.kind = REG_STAT0;
          ADDR_STAT1: stb.kind = REG_STAT1;
          ADDR_STAT2: stb.kind = REG_STAT2;
          ADDR_SPLIT: stb.kind = REG_SPLIT;
          default:    stb.err  = 1'b1;
        endcase
      end
    end
    stb.rdEn = busSel && !busWr && !stb.err;
    stb.wrEn = busSel &&  busWr && !stb.err;
  end
endmodule

// File: rtl/mmu_bank_store.sv
module mmu_bank_store
  import mmu_bank_pkg::*;
#(
  parameter int PHYS_BITS = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic [1:0]        lkMode,
  input  logic              lkSpace,
  input  logic [2:0]        lkSeg,
  output logic [WORD_W-1:0] lkDesc,
  output logic [WORD_W-1:0] lkBase,
  output logic              xlateEnable,
  input  logic              hwSetWritten,
  input  logic              hwSetTrapped,
  input  logic              faultValid,
  input  logic [2:0]        faultKind,
  input  logic [1:0]        faultMode,
  input  logic              faultSpace,
  input  logic [2:0]        faultSeg,
  input  logic [WORD_W-1:0] faultVa
);
  localparam int BASE_W = PHYS_BITS - SEG_UNIT_BITS;

  logic [WORD_W-1:0] descArr [ENTRIES];
  logic [BASE_W-1:0] baseArr [ENTRIES];
  logic [WORD_W-1:0] stat0Q, stat2Q;
  logic [2:0]        splitQ;
  logic [1:0]        lkBank;
  logic              lkValid, splitOn, frozen, stat0Wr;
  logic [IDX_W-1:0]  lkIdx, busIdx;
  logic [WORD_W-1:0] lkBaseExt, busBaseExt;

  always_comb begin
    lkValid = 1'b1;
    lkBank  = BANK_KERN;
    case (lkMode)
      2'b00:   lkBank = BANK_KERN;
      2'b01:   lkBank = BANK_SUPV;
      2'b11:   lkBank = BANK_USER;
      default: lkValid = 1'b0;
    endcase
    case (lkBank)
      BANK_KERN: splitOn = splitQ[2];
      BANK_SUPV: splitOn = splitQ[1];
      default:   splitOn = splitQ[0];
    endcase
  end

  assign lkIdx   = {lkBank, lkSpace & splitOn, lkSeg};
  assign busIdx  = {stb.bank, stb.space, stb.seg};
  assign frozen  = |stat0Q[15:13];
  assign stat0Wr = stb.wrEn && (stb.kind == REG_STAT0);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [WORD_W-1:0] descQ;
    logic [BASE_W-1:0] baseQ;
    logic lkHit, busHit;
    assign lkHit  = lkValid && (lkIdx == IDX_W'(e));
    assign busHit = stb.wrEn && (busIdx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        descQ <= '0;
        baseQ <= '0;
      end else begin
        if (lkHit && hwSetWritten) descQ[FLAG_WRITTEN] <= 1'b1;
        if (lkHit && hwSetTrapped) descQ[FLAG_TRAPPED] <= 1'b1;
        if (busHit && stb.kind == REG_DESC) descQ <= busWdata & DESC_SW_MASK;
        if (busHit && stb.kind == REG_BASE) baseQ <= busWdata[BASE_W-1:0];
      end
    end
    assign descArr[e] = descQ;
    assign baseArr[e] = baseQ;
  end

  if (BASE_W < WORD_W) begin : g_narrow
    assign lkBaseExt  = {{(WORD_W-BASE_W){1'b0}}, baseArr[lkIdx]};
    assign busBaseExt = {{(WORD_W-BASE_W){1'b0}}, baseArr[busIdx]};
  end else begin : g_full
    assign lkBaseExt  = baseArr[lkIdx];
    assign busBaseExt = baseArr[busIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat0Q <= '0;
      stat2Q <= '0;
      splitQ <= '0;
    end else begin
      if (faultValid && !frozen) begin
        stat0Q <= {faultKind, 6'b0, faultMode, faultSpace, faultSeg, stat0Q[0]};
        stat2Q <= faultVa;
      end
      if (stat0Wr) stat0Q <= busWdata & STAT0_MASK;
      if (stb.wrEn && stb.kind == REG_SPLIT) splitQ <= busWdata[2:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdEn) begin
      case (stb.kind)
        REG_DESC:  busRdata = descArr[busIdx];
        REG_BASE:  busRdata = busBaseExt;
        REG_STAT0: busRdata = stat0Q;
        REG_STAT2: busRdata = stat2Q;
        REG_SPLIT: busRdata = {13'b0, splitQ};
        default:   busRdata = '0;
      endcase
    end
  end

  assign lkDesc      = lkValid ? descArr[lkIdx] : '0;
  assign lkBase      = lkValid ? lkBaseExt : '0;
  assign xlateEnable = stat0Q[0];

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lkDesc[15] == 1'b0) && (lkDesc[5:4] == 2'b00));
  p_sw_clears_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.kind == REG_DESC) |=> (descArr[$past(busIdx)][7:6] == 2'b00));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !frozen && !stat0Wr) |=> (stat2Q == $past(faultVa)));
  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !stat0Wr) |=> ($stable(stat2Q) && $stable(stat0Q)));
  p_err_reads_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.err |-> (busRdata == '0));
  p_err_keeps_split_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.err |=> $stable(splitQ));
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_bank_pkg::*;
#(
  parameter int PHYS_BITS = 22
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [17:0] busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        busErr,
  input  logic [1:0]  lkMode,
  input  logic        lkSpace,
  input  logic [2:0]  lkSeg,
  output logic [15:0] lkDesc,
  output logic [15:0] lkBase,
  output logic        xlateEnable,
  input  logic        hwSetWritten,
  input  logic        hwSetTrapped,
  input  logic        faultValid,
  input  logic [2:0]  faultKind,
  input  logic [1:0]  faultMode,
  input  logic        faultSpace,
  input  logic [2:0]  faultSeg,
  input  logic [15:0] faultVa
);
  busStrobe_t stb;

  mmu_bank_decode u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  mmu_bank_store #(.PHYS_BITS(PHYS_BITS)) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .lkMode      (lkMode),
    .lkSpace     (lkSpace),
    .lkSeg       (lkSeg),
    .lkDesc      (lkDesc),
    .lkBase      (lkBase),
    .xlateEnable (xlateEnable),
    .hwSetWritten(hwSetWritten),
    .hwSetTrapped(hwSetTrapped),
    .faultValid  (faultValid),
    .faultKind   (faultKind),
    .faultMode   (faultMode),
    .faultSpace  (faultSpace),
    .faultSeg    (faultSeg),
    .faultVa     (faultVa)
  );

  assign busErr = stb.err;
endmodule

// File: tb/mmu_reg_bank_test.sv
`timescale 1ns/1ps
module mmu_reg_bank_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, busSel, busWr, busErr, busErr2, xlateEnable, xlate2;
  logic [17:0] busAddr;
  logic [15:0] busWdata, busRdata, busRdata2, lkDesc, lkBase, lkDesc2, lkBase2, faultVa;
  logic [1:0]  lkMode, faultMode;
  logic        lkSpace, hwSetWritten, hwSetTrapped, faultValid, faultSpace;
  logic [2:0]  lkSeg, faultKind, faultSeg;
  logic        chkReq, done;

  mmu_reg_bank uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .lkMode(lkMode),
    .lkSpace(lkSpace), .lkSeg(lkSeg), .lkDesc(lkDesc), .lkBase(lkBase),
    .xlateEnable(xlateEnable), .hwSetWritten(hwSetWritten), .hwSetTrapped(hwSetTrapped),
    .faultValid(faultValid), .faultKind(faultKind), .faultMode(faultMode),
    .faultSpace(faultSpace), .faultSeg(faultSeg), .faultVa(faultVa));

  mmu_reg_bank #(.PHYS_BITS(18)) uutNarrow (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata2), .busErr(busErr2), .lkMode(lkMode),
    .lkSpace(lkSpace), .lkSeg(lkSeg), .lkDesc(lkDesc2), .lkBase(lkBase2),
    .xlateEnable(xlate2), .hwSetWritten(hwSetWritten), .hwSetTrapped(hwSetTrapped),
    .faultValid(faultValid), .faultKind(faultKind), .faultMode(faultMode),
    .faultSpace(faultSpace), .faultSeg(faultSeg), .faultVa(faultVa));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];
  int checks = 0;
  int errors = 0;

  // monitor: kind 0 = bus read, 1 = lookup, 2 = narrow bus read, 3 = enable bit
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (chkReq && expQ.size() > 0) begin
      it = expQ.pop_front();
      case (it.kind)
        0:       act = {15'b0, busErr, busRdata};
        1:       act = {lkDesc, lkBase};
        2:       act = {15'b0, busErr2, busRdata2};
        default: act = {31'b0, xlateEnable};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic clearIn();
    busSel = 0; busWr = 0; hwSetWritten = 0; hwSetTrapped = 0; faultValid = 0; chkReq = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1; clearIn();
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(posedge clk); #1; clearIn();
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
  endtask

  task automatic rd(input logic [17:0] a, input logic [15:0] expD, input logic expE,
                    input string tag, input int kind = 0);
    @(posedge clk); #1; clearIn();
    busSel = 1; busAddr = a;
    expQ.push_back('{kind, {15'b0, expE, expD}, tag});
    chkReq = 1;
  endtask

  task automatic chkEnable(input logic expEn, input string tag);
    @(posedge clk); #1; clearIn();
    expQ.push_back('{3, {31'b0, expEn}, tag});
    chkReq = 1;
  endtask

  task automatic look(input logic [1:0] m, input logic s, input logic [2:0] g,
                      input logic [15:0] expD, input logic [15:0] expB, input string tag);
    @(posedge clk); #1; clearIn();
    lkMode = m; lkSpace = s; lkSeg = g;
    expQ.push_back('{1, {expD, expB}, tag});
    chkReq = 1;
  endtask

  task automatic hw(input logic [1:0] m, input logic s, input logic [2:0] g,
                    input logic w, input logic t);
    @(posedge clk); #1; clearIn();
    lkMode = m; lkSpace = s; lkSeg = g; hwSetWritten = w; hwSetTrapped = t;
  endtask

  task automatic collide(input logic [1:0] m, input logic s, input logic [2:0] g,
                         input logic [17:0] a, input logic [15:0] d);
    @(posedge clk); #1; clearIn();
    lkMode = m; lkSpace = s; lkSeg = g; hwSetWritten = 1;
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
  endtask

  task automatic fault(input logic [2:0] k, input logic [1:0] m, input logic s,
                       input logic [2:0] g, input logic [15:0] va);
    @(posedge clk); #1; clearIn();
    faultValid = 1; faultKind = k; faultMode = m; faultSpace = s; faultSeg = g; faultVa = va;
  endtask

  initial begin
    done = 0;
    clearIn();
    busAddr = '0; busWdata = '0; lkMode = '0; lkSpace = 0; lkSeg = '0;
    faultKind = '0; faultMode = '0; faultSpace = 0; faultSeg = '0; faultVa = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rd(18'o777572, 16'h0000, 0, "R1 status0 after reset");
    rd(18'o772300, 16'h0000, 0, "R1 kernel I desc0 after reset");
    rd(18'o777676, 16'h0000, 0, "R1 user D base7 after reset");
    rd(18'o777516, 16'h0000, 0, "R1 split word after reset");
    chkEnable(1'b0, "R1 translation disabled after reset");
    look(2'b00, 0, 3'd0, 16'h0, 16'h0, "R1 lookup after reset");

    // R2 address map
    wr(18'o772346, 16'o012345);
    wr(18'o772272, 16'hBEEF);
    wr(18'o777640, 16'h1234);
    wr(18'o777676, 16'hFFFF);
    rd(18'o772346, 16'o012345, 0, "R2 kernel I base3");
    rd(18'o772272, 16'hBEEF, 0, "R2 supervisor D base5");
    rd(18'o777640, 16'h1234, 0, "R2 user I base0");
    rd(18'o777676, 16'hFFFF, 0, "R4 user D base7 full width");
    rd(18'o772246, 16'h0000, 0, "R2 supervisor I base3 untouched");

    // R3 descriptor masking
    wr(18'o772324, 16'hFFFF);
    rd(18'o772324, 16'h7F0F, 0, "R3 descriptor mask");
    wr(18'o777600, 16'h0102);
    rd(18'o777600, 16'h0102, 0, "R3 user I desc0");

    // R11 split word, R6 lookups
    wr(18'o777516, 16'hFFFF);
    rd(18'o777516, 16'h0007, 0, "R11 split word mask");
    wr(18'o777516, 16'h0004);
    wr(18'o772364, 16'h0A0A);
    look(2'b00, 1, 3'd2, 16'h7F0F, 16'h0A0A, "R6 kernel D seg2 split on");
    look(2'b11, 1, 3'd0, 16'h0102, 16'h1234, "R6 user D seg0 redirected to I");
    look(2'b10, 0, 3'd0, 16'h0000, 16'h0000, "R6 invalid mode returns zero");

    // R5 hardware flags
    hw(2'b00, 1, 3'd2, 1, 0);
    rd(18'o772324, 16'h7F4F, 0, "R5 written flag set");
    hw(2'b00, 1, 3'd2, 0, 1);
    rd(18'o772324, 16'h7FCF, 0, "R5 trapped flag set");
    wr(18'o772324, 16'h00C5);
    rd(18'o772324, 16'h0005, 0, "R5 software write clears flags");
    collide(2'b00, 1, 3'd2, 18'o772324, 16'h0006);
    rd(18'o772324, 16'h0006, 0, "R5 software wins same-cycle pulse");

    // R11 status word 0 fields
    wr(18'o777572, 16'hFFFF);
    rd(18'o777572, 16'hE07F, 0, "R11 status0 mask");
    wr(18'o777572, 16'h0001);
    rd(18'o777572, 16'h0001, 0, "R11 status0 enable");
    chkEnable(1'b1, "R11 enable output");

    // R7 capture, R8 freeze
    fault(3'b010, 2'b11, 1, 3'd5, 16'o123456);
    rd(18'o777572, 16'h407B, 0, "R7 status0 capture");
    rd(18'o777576, 16'o123456, 0, "R7 status2 capture");
    fault(3'b100, 2'b00, 0, 3'd1, 16'h0042);
    rd(18'o777572, 16'h407B, 0, "R8 status0 frozen");
    rd(18'o777576, 16'o123456, 0, "R8 status2 frozen");
    wr(18'o777572, 16'h0001);
    rd(18'o777572, 16'h0001, 0, "R8 software clear");
    fault(3'b001, 2'b01, 0, 3'd7, 16'h0200);
    rd(18'o777572, 16'h202F, 0, "R8 capture after clear");
    rd(18'o777576, 16'h0200, 0, "R8 status2 after clear");

    // R9 status words 1 and 2
    wr(18'o777576, 16'hFFFF);
    rd(18'o777576, 16'h0200, 0, "R9 status2 ignores writes");
    wr(18'o777574, 16'hFFFF);
    rd(18'o777574, 16'h0000, 0, "R9 status1 reads zero");

    // R10 bus errors
    wr(18'o777700, 16'h5555);
    rd(18'o777700, 16'h0000, 1, "R10 unmapped read");
    rd(18'o772301, 16'h0000, 1, "R10 odd address");
    wr(18'o777641, 16'hDEAD);
    rd(18'o777640, 16'h1234, 0, "R10 odd write ignored");
    wr(18'o772400, 16'h0000);
    wr(18'o777520, 16'h0000);
    rd(18'o777516, 16'h0004, 0, "R10 split word unchanged");

    // R4 narrow base width
    wr(18'o772340, 16'hFFFF);
    rd(18'o772340, 16'h0FFF, 0, "R4 narrow base masked", 2);
    rd(18'o772340, 16'hFFFF, 0, "R4 default base full");

    idle();
    idle();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule